// File: doc/BRIEF.md
# Inter-System Frame Propagation Filter

This block sits behind three inter-system links, called L, R and U, and chooses which command frames from a remote system may enter the local system. Each link delivers decoded frames. A frame carries a 5-bit frame number, a payload and a valid strobe. Each link has a 16-bit enable mask, with one bit per propagatable frame number. A frame whose bit is clear is dropped, and the link's saturating blocked-frame counter counts it.

Allowed trigger-decision frames (numbers 3 to 10) are not forwarded at once. They wait in an 8-entry queue per link. A queue is emptied one entry at a time, and only when the local frame sequencer announces that link's re-propagation slot: slot 8 for L, slot 9 for R, slot 10 for U. A re-issued entry carries a mask of outgoing links, and that mask always leaves out the link the entry came from. Allowed frames of other numbers go straight to a per-link forward output one cycle after arrival. Software reaches the masks, counters and overflow flags through a small write/read port.

Top module: `frame_prop_filter`

## Requirements
- R1: After reset all three masks, all counters and all overflow flags read zero, and every remote frame is blocked.
- R2: Register map on `reg_addr`: 0, 1 and 2 are the L, R and U masks, and all 16 bits of each are written and read back unchanged, including reserved bits. 4, 5 and 6 are the L, R and U blocked counters, zero-extended. 7 holds the overflow flags in bits 0 (L), 1 (R) and 2 (U). 3 reads zero. Reads are combinational.
- R3: Mask bit positions 0 to 15 enable frames 1, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 14, 16, 17, 18 and 19 in that order. An enabled frame outside 3..10 appears on that link's `fwd_*` outputs one cycle after arrival, with its number and payload.
- R4: Mask bit 0 (frame 1, the sync command) takes effect only on link L. On R and U, frame 1 is always blocked and counted.
- R5: An enabled frame in 3..10 is queued and not forwarded. A strobe of `slot_valid` with `slot_num` 8, 9 or 10 pops the L, R or U queue respectively, and the entry appears on `rp_*` one cycle later, in arrival order. Other slot numbers pop nothing, and an empty queue yields no `rp_valid`.
- R6: `rp_link_en` (bit 0 L, bit 1 R, bit 2 U) is set for every link except the source link given by `rp_src` (0 L, 1 R, 2 U).
- R7: Frame numbers with no mask bit (0, 2, 13, 15, 20..31) are always blocked and counted.
- R8: Each queue holds 8 entries. A trigger frame accepted while its queue is full is dropped, the queued entries are kept, and the link's overflow flag is set. The flag stays set until a write to address 7 with a 1 in that link's bit.
- R9: Each blocked frame increments that link's 8-bit counter, which saturates at 255. A write to the link's mask register clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 3 | Frame strobe per link (bit 0 L, 1 R, 2 U) |
| rx_frame | input | 15 | Frame numbers, 5 bits per link, L in the lowest bits |
| rx_data | input | 48 | Payloads, 16 bits per link, L in the lowest bits |
| slot_valid | input | 1 | Local sequencer slot strobe |
| slot_num | input | 5 | Current local frame slot number |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| fwd_valid | output | 3 | Forwarded non-trigger frame strobe per link |
| fwd_frame | output | 15 | Forwarded frame numbers per link |
| fwd_data | output | 48 | Forwarded payloads per link |
| rp_valid | output | 1 | Re-propagated trigger decision strobe |
| rp_src | output | 2 | Source link of the re-propagated entry |
| rp_frame | output | 5 | Frame number of the re-propagated entry |
| rp_data | output | 16 | Payload of the re-propagated entry |
| rp_link_en | output | 3 | Outgoing links allowed to carry the entry |

## Verification
The hardest state to reach from the ports is a full queue taking one more accepted trigger frame. Getting there needs a mask that lets a trigger frame in, nine or more arrivals with no strobe of that link's slot in between, and then a slot-by-slot drain that shows the first eight payloads in order and nothing behind them. The bench builds that exact sequence on link L, reads the sticky flag, and clears it. A separate sweep covers every single-bit mask against all 32 frame numbers on each link, so the mapping, the sync restriction to L and the blocked counts are checked together. Driving a long run of unmapped frames brings the counter to saturation.

// File: rtl/frame_prop_pkg.sv
// Shared constants and frame decode helpers for the propagation filter.
// Assumes frame numbers are 5 bits wide and masks are 16 bits wide.
package frame_prop_pkg;

    localparam int NUM_LINKS = 3;
    localparam int FRAME_W   = 5;
    localparam int MASK_W    = 16;
    localparam int SLOT_BASE = 8;

    typedef struct packed {
        logic       hit;
        logic [3:0] pos;
    } frame_map_t;

    // Map a frame number to its mask bit; hit is low for unmapped frames.
    function automatic frame_map_t frame_map(input logic [FRAME_W-1:0] f);
        frame_map_t m;
        m.hit = 1'b1;
        m.pos = 4'd0;
        if (f == 5'd1) begin
            m.pos = 4'd0;
        end else if (f >= 5'd3 && f <= 5'd12) begin
            m.pos = 4'(f - 5'd2);
        end else if (f == 5'd14) begin
            m.pos = 4'd11;
        end else if (f >= 5'd16 && f <= 5'd19) begin
            m.pos = 4'(f - 5'd4);
        end else begin
            m.hit = 1'b0;
        end
        return m;
    endfunction

    // True for trigger-decision frames that are queued rather than forwarded.
    function automatic logic is_trigger(input logic [FRAME_W-1:0] f);
        return (f >= 5'd3) && (f <= 5'd10);
    endfunction

endpackage

// File: rtl/prop_fifo.sv
// Small synchronous FIFO with first-word-fall-through output.
// A push while full and a pop while empty are ignored; the caller
// decides what a refused push means. Depth need not be a power of two.
module prop_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    p_full_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (full && $stable(wr_ptr)));

endmodule

// File: rtl/prop_link_filter.sv
// Per-link filter: holds the link's enable mask, decodes each arriving
// frame, forwards allowed non-trigger frames after one register stage,
// queues allowed trigger decisions, counts blocked frames and flags
// queue overflow. Assumes at most one frame per cycle on the link.
module prop_link_filter
    import frame_prop_pkg::*;
#(
    parameter int LINK_IDX = 0,
    parameter int PAYLOAD_W = 16,
    parameter int Q_DEPTH = 8,
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [FRAME_W-1:0]   rx_frame,
    input  logic [PAYLOAD_W-1:0] rx_data,
    input  logic                 ctrl_we,
    input  logic [MASK_W-1:0]    ctrl_wdata,
    input  logic                 ovf_clr,
    input  logic                 drain,
    output logic [MASK_W-1:0]    ctrl_q,
    output logic [CNT_W-1:0]     cnt_q,
    output logic                 ovf_q,
    output logic                 fwd_valid,
    output logic [FRAME_W-1:0]   fwd_frame,
    output logic [PAYLOAD_W-1:0] fwd_data,
    output logic                 q_valid,
    output logic [FRAME_W-1:0]   q_frame,
    output logic [PAYLOAD_W-1:0] q_data
);
    localparam int ENTRY_W = FRAME_W + PAYLOAD_W;
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [MASK_W-1:0] EFF_MASK = (LINK_IDX == 0) ? 16'hFFFF : 16'hFFFE;

    frame_map_t         map;
    logic               allowed;
    logic               take_trig;
    logic               take_fwd;
    logic               blocked;
    logic               q_empty;
    logic               q_full;
    logic [ENTRY_W-1:0] q_dout;

    // Decode the arriving frame against the effective mask.
    always_comb begin
        map       = frame_map(rx_frame);
        allowed   = map.hit && ctrl_q[map.pos] && EFF_MASK[map.pos];
        take_trig = rx_valid && allowed && is_trigger(rx_frame);
        take_fwd  = rx_valid && allowed && !is_trigger(rx_frame);
        blocked   = rx_valid && !allowed;
    end

    // Mask register, written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Saturating blocked-frame counter, cleared by a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (ctrl_we)                    cnt_q <= '0;
        else if (blocked && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky overflow flag for a trigger refused by a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf_q <= 1'b0;
        else if (take_trig && q_full) ovf_q <= 1'b1;
        else if (ovf_clr)          ovf_q <= 1'b0;
    end

    // One-stage register on the direct forward path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_frame <= '0;
            fwd_data  <= '0;
        end else begin
            fwd_valid <= take_fwd;
            if (take_fwd) begin
                fwd_frame <= rx_frame;
                fwd_data  <= rx_data;
            end
        end
    end

    prop_fifo #(
        .DEPTH (Q_DEPTH),
        .WIDTH (ENTRY_W)
    ) i_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take_trig),
        .din   ({rx_frame, rx_data}),
        .pop   (drain),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    assign q_valid = !q_empty;
    assign q_frame = q_dout[ENTRY_W-1:PAYLOAD_W];
    assign q_data  = q_dout[PAYLOAD_W-1:0];

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == '0 && rx_valid) |=> !fwd_valid);

    p_unmapped_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_frame == 5'd0 || rx_frame == 5'd2 || rx_frame == 5'd13 ||
                      rx_frame == 5'd15 || rx_frame > 5'd19)) |=> !fwd_valid);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    p_cnt_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !ctrl_we) |=> (cnt_q == CNT_MAX));

    if (LINK_IDX != 0) begin : g_no_sync
        p_sync_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid && rx_frame == 5'd1) |=> !fwd_valid);
    end

endmodule

// File: rtl/frame_prop_filter.sv
// Top of the propagation filter: three per-link filters, the register
// port decode, and the slot scheduler that re-issues queued trigger
// decisions in each link's own slot. Assumes the sequencer strobes at
// most one slot number per cycle, so at most one queue pops per cycle.
module frame_prop_filter
    import frame_prop_pkg::*;
#(
    parameter int PAYLOAD_W = 16,
    parameter int Q_DEPTH = 8,
    parameter int CNT_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINKS-1:0]           rx_valid,
    input  logic [NUM_LINKS*FRAME_W-1:0]   rx_frame,
    input  logic [NUM_LINKS*PAYLOAD_W-1:0] rx_data,
    input  logic                           slot_valid,
    input  logic [FRAME_W-1:0]             slot_num,
    input  logic                           reg_we,
    input  logic [2:0]                     reg_addr,
    input  logic [MASK_W-1:0]              reg_wdata,
    output logic [MASK_W-1:0]              reg_rdata,
    output logic [NUM_LINKS-1:0]           fwd_valid,
    output logic [NUM_LINKS*FRAME_W-1:0]   fwd_frame,
    output logic [NUM_LINKS*PAYLOAD_W-1:0] fwd_data,
    output logic                           rp_valid,
    output logic [1:0]                     rp_src,
    output logic [FRAME_W-1:0]             rp_frame,
    output logic [PAYLOAD_W-1:0]           rp_data,
    output logic [NUM_LINKS-1:0]           rp_link_en
);
    localparam logic [2:0] ADDR_OVF = 3'd7;

    logic [MASK_W-1:0]    ctrl_arr   [NUM_LINKS];
    logic [CNT_W-1:0]     cnt_arr    [NUM_LINKS];
    logic [FRAME_W-1:0]   qframe_arr [NUM_LINKS];
    logic [PAYLOAD_W-1:0] qdata_arr  [NUM_LINKS];
    logic [NUM_LINKS-1:0] ovf_vec;
    logic [NUM_LINKS-1:0] q_valid;
    logic [NUM_LINKS-1:0] drain;

    logic                 sel_hit;
    logic [1:0]           sel_idx;
    logic [FRAME_W-1:0]   sel_frame;
    logic [PAYLOAD_W-1:0] sel_data;

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        logic ctrl_we;
        logic ovf_clr;

        // Per-link write strobes and slot match.
        assign ctrl_we  = reg_we && (reg_addr == 3'(i));
        assign ovf_clr  = reg_we && (reg_addr == ADDR_OVF) && reg_wdata[i];
        assign drain[i] = slot_valid && (slot_num == FRAME_W'(SLOT_BASE + i));

        prop_link_filter #(
            .LINK_IDX  (i),
            .PAYLOAD_W (PAYLOAD_W),
            .Q_DEPTH   (Q_DEPTH),
            .CNT_W     (CNT_W)
        ) i_filter (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_valid   (rx_valid[i]),
            .rx_frame   (rx_frame[i*FRAME_W +: FRAME_W]),
            .rx_data    (rx_data[i*PAYLOAD_W +: PAYLOAD_W]),
            .ctrl_we    (ctrl_we),
            .ctrl_wdata (reg_wdata),
            .ovf_clr    (ovf_clr),
            .drain      (drain[i]),
            .ctrl_q     (ctrl_arr[i]),
            .cnt_q      (cnt_arr[i]),
            .ovf_q      (ovf_vec[i]),
            .fwd_valid  (fwd_valid[i]),
            .fwd_frame  (fwd_frame[i*FRAME_W +: FRAME_W]),
            .fwd_data   (fwd_data[i*PAYLOAD_W +: PAYLOAD_W]),
            .q_valid    (q_valid[i]),
            .q_frame    (qframe_arr[i]),
            .q_data     (qdata_arr[i])
        );
    end

    // Combinational register read mux.
    always_comb begin
        case (reg_addr)
            3'd0:    reg_rdata = ctrl_arr[0];
            3'd1:    reg_rdata = ctrl_arr[1];
            3'd2:    reg_rdata = ctrl_arr[2];
            3'd4:    reg_rdata = MASK_W'(cnt_arr[0]);
            3'd5:    reg_rdata = MASK_W'(cnt_arr[1]);
            3'd6:    reg_rdata = MASK_W'(cnt_arr[2]);
            3'd7:    reg_rdata = MASK_W'(ovf_vec);
            default: reg_rdata = '0;
        endcase
    end

    // Pick the queue being drained in this slot, if it holds an entry.
    always_comb begin
        sel_hit   = 1'b0;
        sel_idx   = 2'd0;
        sel_frame = '0;
        sel_data  = '0;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (drain[i] && q_valid[i]) begin
                sel_hit   = 1'b1;
                sel_idx   = 2'(i);
                sel_frame = qframe_arr[i];
                sel_data  = qdata_arr[i];
            end
        end
    end

    // Register the re-propagated entry and its outgoing-link mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_valid   <= 1'b0;
            rp_src     <= 2'd0;
            rp_frame   <= '0;
            rp_data    <= '0;
            rp_link_en <= '0;
        end else begin
            rp_valid <= sel_hit;
            if (sel_hit) begin
                rp_src     <= sel_idx;
                rp_frame   <= sel_frame;
                rp_data    <= sel_data;
                rp_link_en <= ~(NUM_LINKS'(1) << sel_idx);
            end
        end
    end

    p_own_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid |-> ($past(slot_valid) && $past(slot_num) == FRAME_W'(SLOT_BASE) + FRAME_W'(rp_src)));

    p_no_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rp_valid |-> (!rp_link_en[rp_src] && $countones(rp_link_en) == NUM_LINKS - 1));

    p_single_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drain));

endmodule

// File: tb/test_frame_prop_filter.sv
module test_frame_prop_filter;
    localparam int PW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rx_valid = '0;
    logic [14:0] rx_frame = '0;
    logic [47:0] rx_data = '0;
    logic        slot_valid = 1'b0;
    logic [4:0]  slot_num = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  fwd_valid;
    logic [14:0] fwd_frame;
    logic [47:0] fwd_data;
    logic        rp_valid;
    logic [1:0]  rp_src;
    logic [4:0]  rp_frame;
    logic [15:0] rp_data;
    logic [2:0]  rp_link_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    frame_prop_filter i_frame_prop_filter (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_frame(rx_frame),
        .rx_data(rx_data), .slot_valid(slot_valid), .slot_num(slot_num),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fwd_valid(fwd_valid), .fwd_frame(fwd_frame),
        .fwd_data(fwd_data), .rp_valid(rp_valid), .rp_src(rp_src),
        .rp_frame(rp_frame), .rp_data(rp_data), .rp_link_en(rp_link_en)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench-side mask position of a frame number, -1 if none.
    function automatic int exp_pos(input int f);
        case (f)
            1: return 0;   3: return 1;   4: return 2;   5: return 3;
            6: return 4;   7: return 5;   8: return 6;   9: return 7;
            10: return 8;  11: return 9;  12: return 10; 14: return 11;
            16: return 12; 17: return 13; 18: return 14; 19: return 15;
            default: return -1;
        endcase
    endfunction

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        reg_addr = 3'(a);
        #0.5;
        d = int'(reg_rdata);
    endtask

    // Present one frame on one link for one cycle; sample forward outputs after it.
    task automatic send(input int link, input int f, input int d);
        rx_valid[link] = 1'b1;
        rx_frame[link*5 +: 5] = 5'(f);
        rx_data[link*16 +: 16] = 16'(d);
        @(negedge clk);
        rx_valid = '0;
    endtask

    task automatic slot(input int n);
        slot_valid = 1'b1; slot_num = 5'(n);
        @(negedge clk);
        slot_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of all registers.
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk(v == 0, "R1 reset register", v, 0);
        end
        // R1: nothing propagates with zero masks.
        send(0, 1, 16'h11);
        chk(fwd_valid == 3'b000, "R1 sync blocked at reset", fwd_valid, 0);
        send(0, 5, 16'h22);
        slot(8);
        chk(!rp_valid, "R1 trigger blocked at reset", rp_valid, 0);
        rd(4, v);
        chk(v == 2, "R1 counter after reset blocks", v, 2);

        // R2: full-width readback, reserved bits included; address 3 reads zero.
        wr(1, 16'hFFFF);
        rd(1, v);
        chk(v == 16'hFFFF, "R2 mask readback", v, 16'hFFFF);
        rd(3, v);
        chk(v == 0, "R2 unused address", v, 0);
        wr(2, 16'hA5C3);
        rd(2, v);
        chk(v == 16'hA5C3, "R2 mask readback U", v, 16'hA5C3);

        // R3 R4 R5 R6 R7 R9: single-bit mask sweep on every link over every frame number.
        for (int link = 0; link < 3; link++) begin
            for (int b = 0; b < 16; b++) begin
                int nallow;
                nallow = 0;
                wr(link, 1 << b);
                for (int f = 0; f < 32; f++) begin
                    int  d;
                    bit  ok_bit;
                    bit  trig;
                    d = link * 4096 + b * 32 + f;
                    ok_bit = (exp_pos(f) == b) && !(b == 0 && link != 0);
                    trig = (f >= 3 && f <= 10);
                    if (ok_bit) nallow++;
                    send(link, f, d);
                    if (ok_bit && !trig) begin
                        chk(fwd_valid == 3'(1 << link), "R3 forward strobe", fwd_valid, 1 << link);
                        chk(int'(fwd_frame[link*5 +: 5]) == f, "R3 forward frame", fwd_frame[link*5 +: 5], f);
                        chk(int'(fwd_data[link*16 +: 16]) == d, "R3 forward data", fwd_data[link*16 +: 16], d);
                    end else begin
                        chk(fwd_valid == 3'b000, (f == 1) ? "R4 sync filtered" : "R7 frame not forwarded", fwd_valid, 0);
                    end
                    slot(8 + link);
                    if (ok_bit && trig) begin
                        chk(rp_valid && int'(rp_frame) == f && int'(rp_data) == d,
                            "R5 queued trigger reissued", rp_data, d);
                        chk(int'(rp_src) == link && rp_link_en == 3'(7 & ~(1 << link)),
                            "R6 link mask excludes source", rp_link_en, 7 & ~(1 << link));
                    end else begin
                        chk(!rp_valid, "R5 nothing queued", rp_valid, 0);
                    end
                end
                rd(4 + link, v);
                chk(v == 32 - nallow, "R9 blocked count", v, 32 - nallow);
            end
            wr(link, 0);
        end

        // R5: a queued entry waits for its own slot only.
        wr(0, 16'h0008);
        send(0, 5, 16'h0ABC);
        slot(9);
        chk(!rp_valid, "R5 slot 9 does not drain L", rp_valid, 0);
        slot(10);
        chk(!rp_valid, "R5 slot 10 does not drain L", rp_valid, 0);
        slot(7);
        chk(!rp_valid, "R5 slot 7 drains nothing", rp_valid, 0);
        slot(8);
        chk(rp_valid && rp_data == 16'h0ABC, "R5 slot 8 drains L", rp_data, 16'h0ABC);

        // R5 R6: all three links at once, drained in reverse order.
        wr(0, 16'h0004); wr(1, 16'h0004); wr(2, 16'h0004);
        rx_valid = 3'b111;
        rx_frame = {5'd4, 5'd4, 5'd4};
        rx_data = {16'h3003, 16'h2002, 16'h1001};
        @(negedge clk);
        rx_valid = '0;
        for (int k = 2; k >= 0; k--) begin
            slot(8 + k);
            chk(rp_valid && int'(rp_src) == k && int'(rp_data) == (k + 1) * 16'h1001,
                "R5 simultaneous drain", rp_data, (k + 1) * 16'h1001);
            chk(rp_link_en == 3'(7 & ~(1 << k)), "R6 simultaneous link mask", rp_link_en, 7 & ~(1 << k));
        end

        // R8: overflow of the L queue.
        wr(0, 16'h0008);
        for (int k = 0; k < 10; k++) send(0, 5, 100 + k);
        rd(7, v);
        chk(v == 1, "R8 overflow flag L only", v, 1);
        for (int k = 0; k < 8; k++) begin
            slot(8);
            chk(rp_valid && int'(rp_data) == 100 + k, "R8 kept entries in order", rp_data, 100 + k);
        end
        slot(8);
        chk(!rp_valid, "R8 dropped entries absent", rp_valid, 0);
        rd(7, v);
        chk(v == 1, "R8 flag sticky", v, 1);
        wr(7, 16'h0006);
        rd(7, v);
        chk(v == 1, "R8 clear of other bits keeps L", v, 1);
        wr(7, 16'h0001);
        rd(7, v);
        chk(v == 0, "R8 flag cleared", v, 0);

        // R9: saturation then clear on mask write.
        wr(0, 0);
        rx_valid[0] = 1'b1;
        rx_frame[4:0] = 5'd2;
        repeat (300) @(negedge clk);
        rx_valid = '0;
        rd(4, v);
        chk(v == 255, "R9 counter saturates", v, 255);
        wr(0, 0);
        rd(4, v);
        chk(v == 0, "R9 counter cleared by mask write", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule